// File: doc/BRIEF.md
# Reset and Boot Sequencing Controller

This block takes the device from a brownout or power-up reset to its first instruction. While reset is applied, and for a programmable settle window after it is released, it forces the start-up conditions onto the rest of the chip: a request to zero the CPU status word, a request to run the watchdog in its watchdog mode, a request to put the dual-use reset/NMI pin in its reset function, and an input-only request for every I/O line. Once the window ends, the block loads the program counter with the fixed start address of the boot routine and lets the CPU run.

When the boot routine signals that it is finished, the CPU is halted. The block then makes a single read of the reset-vector word at address FFFEh through a request/valid memory port, and it waits as long as the memory needs. A vector other than FFFFh is loaded into the program counter and execution resumes there. An all-ones vector marks an unprogrammed part. In that case the CPU stays halted and the block raises a request for the deepest low-power mode, which it holds until the next reset. A reset at any point restarts the whole sequence.

Top module: `rst_boot_seq`

## Requirements
- R1: While `rst` is high, and in the first cycle after a clock edge with `rst` high, `sr_clr`, `wdt_arm` and `rstpin_rst` are 1, every bit of `io_force_in` is 1, and `cpu_run`, `pc_load`, `mem_req` and `lpm_deep` are 0.
- R2: After `rst` falls, the forced conditions of R1 hold for HOLD_CYCLES clock edges. On edge number HOLD_CYCLES the block enters the boot stage.
- R3: On entry to the boot stage, `pc` equals BOOT_ADDR and `pc_load` is 1 for exactly one cycle. `cpu_run` becomes 1, and `sr_clr`, `wdt_arm`, `rstpin_rst` and `io_force_in` return to 0.
- R4: `boot_done` sampled high during the boot stage causes `mem_req` = 1 and `cpu_run` = 0 in the next cycle. `mem_addr` reads VEC_ADDR (FFFEh). `boot_done` and `mem_rvalid` have no effect outside the stage that uses them.
- R5: `mem_req` stays high until the edge on which `mem_rvalid` is seen and falls in the cycle after that edge. Exactly one read is made per start-up.
- R6: A vector word other than all ones, returned with `mem_rvalid`, appears on `pc` with a one-cycle `pc_load` pulse and `cpu_run` = 1 in the next cycle. The block then stays in the run state.
- R7: An all-ones vector word gives `lpm_deep` = 1 with `cpu_run` = 0 and no `pc_load` from the next cycle on. This holds until reset, whatever `boot_done` and `mem_rvalid` do.
- R8: Raising `rst` in any state, including during the vector read, returns the block to the forced conditions of R1 and restarts the sequence at R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high brownout / power-up reset |
| boot_done | input | 1 | Boot routine finished |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | DATA_W | Read data (reset-vector word) |
| mem_req | output | 1 | Read request, held until valid |
| mem_addr | output | ADDR_W | Read address, fixed at VEC_ADDR |
| pc | output | ADDR_W | Program counter value to load |
| pc_load | output | 1 | One-cycle strobe: load `pc` |
| cpu_run | output | 1 | CPU execution enable |
| lpm_deep | output | 1 | Request for the deepest low-power mode |
| sr_clr | output | 1 | Force status word to zero |
| wdt_arm | output | 1 | Force watchdog on, in watchdog mode |
| rstpin_rst | output | 1 | Force reset/NMI pin to its reset function |
| io_force_in | output | IO_W | Force each I/O line to input |

## Verification
Every output is registered from the next-state decision, so each result appears in the first cycle after the edge that samples its cause. The boot stage is visible HOLD_CYCLES edges after reset falls, and the read request one edge after `boot_done`. The jump or the sleep request follows one edge after `mem_rvalid`. The bench drives inputs and samples outputs on the falling clock edge, and it counts rising edges between a stimulus and its check to match these latencies. Random boot lengths, memory latencies and vector words, with forced all-ones words and resets in mid-read, confirm that the outputs hold steady between events.

// File: rtl/rbs_pkg.sv
package rbs_pkg;
  typedef enum logic [2:0] {
    ST_HOLD  = 3'd0,
    ST_BOOT  = 3'd1,
    ST_FETCH = 3'd2,
    ST_RUN   = 3'd3,
    ST_SLEEP = 3'd4
  } rbs_state_e;
endpackage

// File: rtl/rbs_hold_timer.sv
module rbs_hold_timer #(
  parameter int N = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic expired
);
  localparam int CW = $clog2(N + 1) + 1;
  localparam logic [CW-1:0] LAST = CW'(N - 1);

  logic [CW-1:0] cnt;

  assign expired = run && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst || !run) cnt <= '0;
    else if (!expired) cnt <= cnt + 1'b1;
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    cnt <= LAST); // R2
endmodule

// File: rtl/rbs_vec_fetch.sv
module rbs_vec_fetch #(
  parameter int DATA_W = 16
) (
  input  logic              active,
  input  logic              rvalid,
  input  logic [DATA_W-1:0] rdata,
  output logic              done,
  output logic              blank
);
  assign done  = active && rvalid;
  assign blank = &rdata;
endmodule

// File: rtl/rbs_init_drive.sv
module rbs_init_drive #(
  parameter int IO_W = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            hold_nxt,
  output logic            sr_clr,
  output logic            wdt_arm,
  output logic            rstpin_rst,
  output logic [IO_W-1:0] io_force_in
);
  always_ff @(posedge clk) begin
    if (rst) begin
      sr_clr     <= 1'b1;
      wdt_arm    <= 1'b1;
      rstpin_rst <= 1'b1;
    end else begin
      sr_clr     <= hold_nxt;
      wdt_arm    <= hold_nxt;
      rstpin_rst <= hold_nxt;
    end
  end

  for (genvar g = 0; g < IO_W; g++) begin : g_io
    always_ff @(posedge clk) begin
      if (rst) io_force_in[g] <= 1'b1;
      else     io_force_in[g] <= hold_nxt;
    end
  end

  AST_INIT_TOGETHER: assert property (@(posedge clk) disable iff (rst)
    sr_clr |-> (wdt_arm && rstpin_rst && (&io_force_in))); // R1
endmodule

// File: rtl/rst_boot_seq.sv
module rst_boot_seq
  import rbs_pkg::*;
#(
  parameter int              ADDR_W      = 16,
  parameter int              DATA_W      = 16,
  parameter int              IO_W        = 16,
  parameter int              HOLD_CYCLES = 4,
  parameter logic [ADDR_W-1:0] BOOT_ADDR = 16'h1000,
  parameter logic [ADDR_W-1:0] VEC_ADDR  = 16'hFFFE
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              boot_done,
  input  logic              mem_rvalid,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [ADDR_W-1:0] pc,
  output logic              pc_load,
  output logic              cpu_run,
  output logic              lpm_deep,
  output logic              sr_clr,
  output logic              wdt_arm,
  output logic              rstpin_rst,
  output logic [IO_W-1:0]   io_force_in
);
  rbs_state_e state, nxt;
  logic hold_exp, vec_done, vec_blank;
  logic enter_boot, enter_run;

  rbs_hold_timer #(.N(HOLD_CYCLES)) u_timer (
    .clk(clk), .rst(rst), .run(state == ST_HOLD), .expired(hold_exp)
  );

  rbs_vec_fetch #(.DATA_W(DATA_W)) u_fetch (
    .active(state == ST_FETCH && mem_req), .rvalid(mem_rvalid),
    .rdata(mem_rdata), .done(vec_done), .blank(vec_blank)
  );

  rbs_init_drive #(.IO_W(IO_W)) u_init (
    .clk(clk), .rst(rst), .hold_nxt(nxt == ST_HOLD),
    .sr_clr(sr_clr), .wdt_arm(wdt_arm), .rstpin_rst(rstpin_rst),
    .io_force_in(io_force_in)
  );

  always_comb begin
    nxt = state;
    unique case (state)
      ST_HOLD:  if (hold_exp)  nxt = ST_BOOT;
      ST_BOOT:  if (boot_done) nxt = ST_FETCH;
      ST_FETCH: if (vec_done)  nxt = vec_blank ? ST_SLEEP : ST_RUN;
      ST_RUN:   nxt = ST_RUN;
      ST_SLEEP: nxt = ST_SLEEP;
      default:  nxt = ST_HOLD;
    endcase
  end

  assign enter_boot = (state == ST_HOLD)  && (nxt == ST_BOOT);
  assign enter_run  = (state == ST_FETCH) && (nxt == ST_RUN);
  assign mem_addr   = VEC_ADDR;

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_HOLD;
      cpu_run  <= 1'b0;
      mem_req  <= 1'b0;
      lpm_deep <= 1'b0;
      pc_load  <= 1'b0;
      pc       <= '0;
    end else begin
      state    <= nxt;
      cpu_run  <= (nxt == ST_BOOT) || (nxt == ST_RUN);
      mem_req  <= (nxt == ST_FETCH);
      lpm_deep <= (nxt == ST_SLEEP);
      pc_load  <= enter_boot || enter_run;
      if (enter_boot)     pc <= BOOT_ADDR;
      else if (enter_run) pc <= ADDR_W'(mem_rdata);
    end
  end

  AST_RESET_INIT: assert property (@(posedge clk)
    rst |=> (sr_clr && wdt_arm && rstpin_rst && !cpu_run && !mem_req && !lpm_deep && !pc_load)); // R8
  AST_BOOT_PC: assert property (@(posedge clk) disable iff (rst)
    ($rose(cpu_run) && $past(state) == ST_HOLD) |-> (pc == BOOT_ADDR && pc_load)); // R3
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_rvalid) |=> mem_req); // R5
  AST_REQ_DROP: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_rvalid) |=> !mem_req); // R5
  AST_NO_BLANK_JUMP: assert property (@(posedge clk) disable iff (rst)
    (state == ST_RUN) |-> (cpu_run && pc != '1)); // R6
  AST_SLEEP_LOCK: assert property (@(posedge clk) disable iff (rst)
    lpm_deep |=> (lpm_deep && !cpu_run && !pc_load)); // R7
  AST_ONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    pc_load |=> !pc_load); // R3
endmodule

// File: tb/rst_boot_seq_tb_top.sv
module rst_boot_seq_tb_top;
  localparam int AW = 16, DW = 16, IOW = 16, HOLD = 4;
  localparam logic [15:0] BOOT_A = 16'h1000;
  localparam logic [15:0] VEC_A  = 16'hFFFE;

  logic clk = 1'b0, rst = 1'b1, boot_done = 1'b0, mem_rvalid = 1'b0;
  logic [DW-1:0] mem_rdata = '0;
  logic mem_req, pc_load, cpu_run, lpm_deep, sr_clr, wdt_arm, rstpin_rst;
  logic [AW-1:0] mem_addr, pc;
  logic [IOW-1:0] io_force_in;

  int n_chk = 0, n_bad = 0;

  always #2 clk = ~clk;

  rst_boot_seq #(.ADDR_W(AW), .DATA_W(DW), .IO_W(IOW), .HOLD_CYCLES(HOLD),
                 .BOOT_ADDR(BOOT_A), .VEC_ADDR(VEC_A)) dut_i (
    .clk(clk), .rst(rst), .boot_done(boot_done), .mem_rvalid(mem_rvalid),
    .mem_rdata(mem_rdata), .mem_req(mem_req), .mem_addr(mem_addr), .pc(pc),
    .pc_load(pc_load), .cpu_run(cpu_run), .lpm_deep(lpm_deep), .sr_clr(sr_clr),
    .wdt_arm(wdt_arm), .rstpin_rst(rstpin_rst), .io_force_in(io_force_in)
  );

  function automatic bit vec_runs(logic [15:0] w);
    return w != 16'hFFFF;
  endfunction

  function automatic logic [15:0] exp_pc(logic [15:0] w);
    return w;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] init_vec();
    return {25'd0, sr_clr, wdt_arm, rstpin_rst, &io_force_in, cpu_run, mem_req, lpm_deep | pc_load};
  endfunction

  localparam logic [31:0] INIT_EXP = 32'b1111000;

  task automatic cyc();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic do_reset(input string tag);
    rst = 1'b1; boot_done = 1'b0; mem_rvalid = 1'b0;
    cyc();
    chk(init_vec() == INIT_EXP, tag, init_vec(), INIT_EXP);
    cyc();
    chk(init_vec() == INIT_EXP, tag, init_vec(), INIT_EXP);
    rst = 1'b0;
  endtask

  task automatic to_boot();
    for (int k = 1; k < HOLD; k++) begin
      cyc();
      chk(init_vec() == INIT_EXP, "R2", init_vec(), INIT_EXP);
    end
    cyc();
    chk(cpu_run && pc_load && pc == BOOT_A, "R3", {pc, 14'd0, cpu_run, pc_load}, {BOOT_A, 16'd3});
    chk(!sr_clr && !wdt_arm && !rstpin_rst && io_force_in == '0, "R3",
        {sr_clr, wdt_arm, rstpin_rst, |io_force_in}, 0);
  endtask

  task automatic trial(input logic [15:0] word, input int boot_len, input int lat, input bit mid_rst);
    do_reset("R1");
    to_boot();
    for (int k = 0; k < boot_len; k++) begin
      mem_rvalid = k[0]; mem_rdata = 16'h0BAD;
      cyc();
      chk(cpu_run && !pc_load && !mem_req, "R4", {cpu_run, pc_load, mem_req}, 3'b100);
    end
    mem_rvalid = 1'b0;
    boot_done = 1'b1;
    cyc();
    boot_done = 1'b0;
    chk(mem_req && !cpu_run && mem_addr == VEC_A, "R4", {mem_addr, 14'd0, mem_req, cpu_run}, {VEC_A, 16'd2});
    if (mid_rst) begin
      do_reset("R8");
      to_boot();
      return;
    end
    for (int k = 0; k < lat; k++) begin
      cyc();
      chk(mem_req && !cpu_run && !pc_load, "R5", {mem_req, cpu_run, pc_load}, 3'b100);
    end
    mem_rvalid = 1'b1; mem_rdata = word;
    cyc();
    mem_rvalid = 1'b0; mem_rdata = 16'h5555;
    chk(!mem_req, "R5", mem_req, 0);
    if (vec_runs(word)) begin
      chk(cpu_run && pc_load && pc == exp_pc(word) && !lpm_deep, "R6",
          {pc, 13'd0, cpu_run, pc_load, lpm_deep}, {exp_pc(word), 16'd6});
    end else begin
      chk(lpm_deep && !cpu_run && !pc_load, "R7", {lpm_deep, cpu_run, pc_load}, 3'b100);
    end
    for (int k = 0; k < 3; k++) begin
      boot_done = 1'b1; mem_rvalid = 1'b1;
      cyc();
      boot_done = 1'b0; mem_rvalid = 1'b0;
      if (vec_runs(word))
        chk(cpu_run && !pc_load && !mem_req && pc == exp_pc(word), "R6",
            {pc, 14'd0, cpu_run, pc_load | mem_req}, {exp_pc(word), 16'd2});
      else
        chk(lpm_deep && !cpu_run && !pc_load && !mem_req, "R7",
            {lpm_deep, cpu_run, pc_load, mem_req}, 4'b1000);
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    @(negedge clk);
    trial(16'h4400, 0, 0, 1'b0);
    trial(16'hFFFF, 2, 3, 1'b0);
    trial(16'hFFFE, 1, 0, 1'b0);
    trial(16'h0000, 0, 5, 1'b0);
    trial(16'h8000, 3, 2, 1'b1);
    for (int t = 0; t < 40; t++) begin
      logic [15:0] w;
      w = ($urandom_range(0, 3) == 0) ? 16'hFFFF : 16'($urandom());
      trial(w, $urandom_range(0, 5), $urandom_range(0, 6), $urandom_range(0, 4) == 0);
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule